// File: doc/BRIEF.md
# ADC Calibration Sequencer

This block steers the one-shot self-calibration of a successive-approximation converter. Software raises a calibration request while the converter is powered. The sequencer then holds the request until the converter has been powered long enough. Next it steps through every capacitor of the array, giving each one a fixed measurement slot. In each slot it samples a comparator input (a stub standing in for the analog error measurement) and condenses the samples into one correction code per capacitor. The codes are kept in a register bank so that later conversions can subtract each capacitor's error.

The calibration bit reads back as busy from the request until the last slot ends, and hardware clears it at that point. While the bit is set, conversion-start requests are blocked. When the sequence completes, the code of the last capacitor is written into the data register and a sticky calibrated flag rises. Dropping the power-on input at any time aborts the sequence and invalidates the stored codes.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset, cal_busy_o, calibrated_o, code_valid_o and conv_start_o are 0 and data_o is 0.
- R2: If pwr_on_i was sampled high on at least two clock edges before the edge that samples cal_set_i=1, cal_busy_o is 1 after that request edge. The comparator is then sampled on each of the next CAP_N*SLOT_LEN = 40 edges.
- R3: A request sampled before the power-on window is met (the same edge on which pwr_on_i is first sampled high, or the next one) is held pending with cal_busy_o = 1. The first comparator sample is taken two edges after the second edge on which pwr_on_i is sampled high.
- R4: The code of capacitor i is the number of edges, among measurement samples 4i to 4i+3, on which cmp_i was 1 (range 0 to 4). It appears on code_o when code_sel_i = i, and code_valid_o is 1 once calibration completes.
- R5: After the edge of the last measurement sample, cal_busy_o is 0, calibrated_o is 1, and data_o holds the code of capacitor CAP_N-1 (index 9), zero-extended.
- R6: conv_start_o is 1 in the cycle after an edge that samples conv_req_i=1 while powered, past the power-on window and not calibrating. It stays 0 for conv_req_i while cal_busy_o is 1 or power is off.
- R7: An edge that samples pwr_on_i=0 leaves cal_busy_o, code_valid_o and calibrated_o at 0, and data_o unchanged.
- R8: cal_set_i is ignored while pwr_on_i is 0 (cal_busy_o stays 0). It is also ignored while cal_busy_o is 1: the running sequence completes at the same edge as it would without the second request.
- R9: calibrated_o stays 1 through a new calibration until power-off, while code_valid_o drops to 0 from the request edge until completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_on_i | input | 1 | Power-on control bit |
| cal_set_i | input | 1 | Software write of 1 to the calibration bit |
| conv_req_i | input | 1 | Conversion start request |
| cmp_i | input | 1 | Stub comparator result |
| code_sel_i | input | IDX_W (4) | Selects which stored correction code is read |
| cal_busy_o | output | 1 | Calibration bit readback (cleared by hardware) |
| calibrated_o | output | 1 | Sticky calibration-complete flag |
| conv_start_o | output | 1 | Accepted conversion start, one cycle |
| code_valid_o | output | 1 | Stored codes are valid |
| code_o | output | CODE_W (3) | Selected correction code |
| data_o | output | DATA_W (12) | Data register |

## Verification
cal_busy_o, code_valid_o, calibrated_o and data_o are registered, so each one changes after the edge that samples the request, the last measurement or the power drop. conv_start_o also follows one edge after the edge that samples conv_req_i, and code_o follows code_sel_i combinationally. The bench keeps its own edge counter and logs the comparator bit sampled at every edge. From the request edge and the second powered edge it computes the first measurement edge. It then checks busy just before the final measurement edge and checks every result at the falling edge right after it, summing the logged bits of each four-edge slot for the expected codes.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_HOLD = 2'd1,
    CS_MEAS = 2'd2
  } cal_state_e;

  // One comparator sample added to a running slot count.
  function automatic int unsigned slot_add(int unsigned acc, logic hit);
    return acc + (hit ? 32'd1 : 32'd0);
  endfunction

endpackage

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
  parameter int MIN_ON = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on_i,
  output logic ready_o
);
  localparam int CW = $clog2(MIN_ON + 1);

  logic [CW-1:0] on_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                     on_cnt <= '0;
    else if (!pwr_on_i)             on_cnt <= '0;
    else if (on_cnt < CW'(MIN_ON))  on_cnt <= on_cnt + 1'b1;
  end

  assign ready_o = (on_cnt == CW'(MIN_ON));

  // R3: readiness can only follow a powered cycle
  a_r3_ready_after_on: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> $past(pwr_on_i));

endmodule

// File: rtl/adc_cal_fsm.sv
module adc_cal_fsm
  import adc_cal_pkg::*;
#(
  parameter int CAP_N    = 10,
  parameter int SLOT_LEN = 4,
  localparam int CODE_W  = $clog2(SLOT_LEN + 1),
  localparam int IDX_W   = (CAP_N > 1) ? $clog2(CAP_N) : 1,
  localparam int PH_W    = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on_i,
  input  logic              pwr_ready_i,
  input  logic              cal_set_i,
  input  logic              cmp_i,
  output logic              busy_o,
  output logic              meas_active_o,
  output logic              accept_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [CODE_W-1:0] wr_code_o,
  output logic              done_o
);
  cal_state_e        state;
  logic [PH_W-1:0]   phase;
  logic [IDX_W-1:0]  cap_idx;
  logic [CODE_W-1:0] acc;
  logic              slot_end;
  logic              last_cap;

  assign slot_end  = (phase == PH_W'(SLOT_LEN - 1));
  assign last_cap  = (cap_idx == IDX_W'(CAP_N - 1));
  assign accept_o  = pwr_on_i && cal_set_i && (state == CS_IDLE);
  assign wr_en_o   = pwr_on_i && (state == CS_MEAS) && slot_end;
  assign wr_idx_o  = cap_idx;
  assign wr_code_o = CODE_W'(slot_add(32'(acc), cmp_i));
  assign done_o    = wr_en_o && last_cap;
  assign busy_o    = (state != CS_IDLE);
  assign meas_active_o = (state == CS_MEAS);

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_on_i) begin
      state   <= CS_IDLE;
      phase   <= '0;
      cap_idx <= '0;
      acc     <= '0;
    end else begin
      case (state)
        CS_IDLE: if (cal_set_i) begin
          state   <= pwr_ready_i ? CS_MEAS : CS_HOLD;
          phase   <= '0;
          cap_idx <= '0;
          acc     <= '0;
        end
        CS_HOLD: if (pwr_ready_i) state <= CS_MEAS;
        CS_MEAS: begin
          if (slot_end) begin
            phase <= '0;
            acc   <= '0;
            if (last_cap) state   <= CS_IDLE;
            else          cap_idx <= cap_idx + 1'b1;
          end else begin
            phase <= phase + 1'b1;
            acc   <= wr_code_o;
          end
        end
        default: state <= CS_IDLE;
      endcase
    end
  end

  // R8: a second request during a run does not restart the capacitor walk
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_active_o && pwr_on_i && !slot_end) |=> $stable(cap_idx));

endmodule

// File: rtl/adc_code_bank.sv
module adc_code_bank #(
  parameter int CAP_N   = 10,
  parameter int CODE_W  = 3,
  parameter int DATA_W  = 12,
  localparam int IDX_W  = (CAP_N > 1) ? $clog2(CAP_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on_i,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic              done_i,
  input  logic [IDX_W-1:0]  sel_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o,
  output logic              calibrated_o,
  output logic [DATA_W-1:0] data_o
);
  logic [CODE_W-1:0] codes [CAP_N];

  for (genvar g = 0; g < CAP_N; g++) begin : g_cap
    always_ff @(posedge clk) begin
      if (!rst_n)                                    codes[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))     codes[g] <= wr_code_i;
    end
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < CAP_N; i++)
      if (sel_i == IDX_W'(i)) code_o = codes[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o      <= 1'b0;
      calibrated_o <= 1'b0;
      data_o       <= '0;
    end else if (!pwr_on_i) begin
      valid_o      <= 1'b0;
      calibrated_o <= 1'b0;
    end else begin
      if (clr_i)       valid_o <= 1'b0;
      else if (done_i) valid_o <= 1'b1;
      if (done_i) begin
        calibrated_o <= 1'b1;
        data_o       <= DATA_W'(wr_code_i);
      end
    end
  end

  // R9: the calibrated flag only falls through power-off
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (calibrated_o && pwr_on_i) |=> calibrated_o);

endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq #(
  parameter int CAP_N    = 10,
  parameter int SLOT_LEN = 4,
  parameter int MIN_ON   = 2,
  parameter int DATA_W   = 12,
  localparam int CODE_W  = $clog2(SLOT_LEN + 1),
  localparam int IDX_W   = (CAP_N > 1) ? $clog2(CAP_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on_i,
  input  logic              cal_set_i,
  input  logic              conv_req_i,
  input  logic              cmp_i,
  input  logic [IDX_W-1:0]  code_sel_i,
  output logic              cal_busy_o,
  output logic              calibrated_o,
  output logic              conv_start_o,
  output logic              code_valid_o,
  output logic [CODE_W-1:0] code_o,
  output logic [DATA_W-1:0] data_o
);
  logic              pwr_ready;
  logic              meas_active;
  logic              accept;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [CODE_W-1:0] wr_code;
  logic              cal_done;

  adc_pwr_timer #(.MIN_ON(MIN_ON)) u_timer (
    .clk(clk), .rst_n(rst_n), .pwr_on_i(pwr_on_i), .ready_o(pwr_ready)
  );

  adc_cal_fsm #(.CAP_N(CAP_N), .SLOT_LEN(SLOT_LEN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_on_i(pwr_on_i), .pwr_ready_i(pwr_ready),
    .cal_set_i(cal_set_i), .cmp_i(cmp_i), .busy_o(cal_busy_o),
    .meas_active_o(meas_active), .accept_o(accept), .wr_en_o(wr_en),
    .wr_idx_o(wr_idx), .wr_code_o(wr_code), .done_o(cal_done)
  );

  adc_code_bank #(.CAP_N(CAP_N), .CODE_W(CODE_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .pwr_on_i(pwr_on_i), .clr_i(accept),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_code_i(wr_code), .done_i(cal_done),
    .sel_i(code_sel_i), .code_o(code_o), .valid_o(code_valid_o),
    .calibrated_o(calibrated_o), .data_o(data_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) conv_start_o <= 1'b0;
    else        conv_start_o <= conv_req_i && pwr_on_i && pwr_ready && !cal_busy_o;
  end

  // R3: measuring only happens once the power-on window is met
  a_r3_meas_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_active && pwr_on_i) |-> pwr_ready);

  // R5: the calibration bit is cleared by hardware after the last slot
  a_r5_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> (!cal_busy_o && calibrated_o && code_valid_o));

  // R6: no conversion start while calibration runs
  a_r6_conv_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy_o |=> !conv_start_o);

  // R7: power-off aborts and invalidates
  a_r7_power_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on_i |=> (!cal_busy_o && !code_valid_o && !calibrated_o));

  // R4: codes are only flagged valid outside a calibration
  a_r4_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid_o |-> !cal_busy_o);

endmodule

// File: tb/test_adc_cal_seq.sv
module test_adc_cal_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NCAP = 10;
  localparam int SLOT = 4;
  localparam int LOGN = 8192;

  logic clk = 1'b0;
  logic rst_n, pwr_on_i, cal_set_i, conv_req_i, cmp_i;
  logic [3:0]  code_sel_i;
  logic        cal_busy_o, calibrated_o, conv_start_o, code_valid_o;
  logic [2:0]  code_o;
  logic [11:0] data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_cal_seq i_adc_cal_seq (
    .clk(clk), .rst_n(rst_n), .pwr_on_i(pwr_on_i), .cal_set_i(cal_set_i),
    .conv_req_i(conv_req_i), .cmp_i(cmp_i), .code_sel_i(code_sel_i),
    .cal_busy_o(cal_busy_o), .calibrated_o(calibrated_o),
    .conv_start_o(conv_start_o), .code_valid_o(code_valid_o),
    .code_o(code_o), .data_o(data_o)
  );

  int unsigned cyc = 0;
  bit log_q [LOGN];
  int total = 0, bad = 0;
  int p2 = 0;

  always @(posedge clk) begin
    log_q[cyc % LOGN] <= cmp_i;
    cyc <= cyc + 1;
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cmp_i = 1'($urandom_range(0, 1));
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Expected code: number of comparator highs in the slot of capacitor i.
  function automatic int exp_code(int m1, int i);
    int s = 0;
    for (int k = 0; k < SLOT; k++) s += int'(log_q[(m1 + SLOT*i + k) % LOGN]);
    return s;
  endfunction

  task automatic run_cal(bit poke_mid, bit conv_during);
    int e_req, m1, conv_bad;
    bit prev_cal;
    string rq;
    prev_cal = calibrated_o;
    cal_set_i = 1'b1;
    e_req = cyc;
    tick();
    cal_set_i = 1'b0;
    m1 = (e_req > p2) ? e_req + 1 : p2 + 2;
    rq = (e_req > p2) ? "R2" : "R3";
    check({rq, " busy after request"}, cal_busy_o, 1);
    check("R9 calibrated kept", calibrated_o, prev_cal);
    check("R9 valid dropped", code_valid_o, 0);
    conv_req_i = conv_during;
    conv_bad = 0;
    while (cyc < m1 + SLOT*NCAP - 1) begin
      cal_set_i = poke_mid && (cyc == m1 + 5);
      tick();
      if (conv_start_o) conv_bad++;
    end
    cal_set_i = 1'b0;
    check({rq, " busy before last sample"}, cal_busy_o, 1);
    conv_req_i = 1'b0;
    tick();
    check("R5 busy cleared", cal_busy_o, 0);
    check("R5 calibrated", calibrated_o, 1);
    check("R5 data register", data_o, exp_code(m1, NCAP - 1));
    check("R4 valid", code_valid_o, 1);
    if (conv_during) check("R6 conv blocked", conv_bad, 0);
    for (int i = 0; i < NCAP; i++) begin
      code_sel_i = 4'(i);
      #1;
      check($sformatf("R4 code %0d", i), code_o, exp_code(m1, i));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [11:0] held;
    void'($urandom(32'd4242));
    rst_n = 1'b0; pwr_on_i = 1'b0; cal_set_i = 1'b0; conv_req_i = 1'b0;
    cmp_i = 1'b0; code_sel_i = '0;
    repeat (3) tick();
    check("R1 busy", cal_busy_o, 0);
    check("R1 calibrated", calibrated_o, 0);
    check("R1 valid", code_valid_o, 0);
    check("R1 conv", conv_start_o, 0);
    check("R1 data", data_o, 0);
    rst_n = 1'b1;
    tick();

    // R3: request on the very edge power comes up
    pwr_on_i = 1'b1; p2 = cyc + 1;
    run_cal(1'b0, 1'b0);

    // R2, R6, R8, R9: powered request with a second request and conversions mid-run
    run_cal(1'b1, 1'b1);

    // R6: conversion accepted when idle
    conv_req_i = 1'b1; tick(); conv_req_i = 1'b0;
    check("R6 conv accepted", conv_start_o, 1);
    tick();
    check("R6 conv single", conv_start_o, 0);

    // R7: abort by power-off
    held = data_o;
    cal_set_i = 1'b1; tick(); cal_set_i = 1'b0;
    repeat ($urandom_range(3, 20)) tick();
    check("R7 running", cal_busy_o, 1);
    pwr_on_i = 1'b0; tick();
    check("R7 busy", cal_busy_o, 0);
    check("R7 valid", code_valid_o, 0);
    check("R7 calibrated", calibrated_o, 0);
    check("R7 data kept", data_o, held);

    // R8 / R6: requests while unpowered
    cal_set_i = 1'b1; conv_req_i = 1'b1; tick(); cal_set_i = 1'b0;
    check("R8 cal ignored unpowered", cal_busy_o, 0);
    check("R6 conv ignored unpowered", conv_start_o, 0);
    conv_req_i = 1'b0; tick();

    // random power-up delays and request options
    for (int n = 0; n < 8; n++) begin
      int d;
      pwr_on_i = 1'b0; tick();
      pwr_on_i = 1'b1; p2 = cyc + 1;
      d = $urandom_range(0, 4);
      repeat (d) tick();
      run_cal(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    finish_run();
  end
endmodule